// File: doc/BRIEF.md
# Real-Time Output Buffer Unit

This block holds six bits of output data ahead of time, so that they reach the pins at a precise moment set by hardware. The data sits in two buffer fields. The low field is a 4-bit nibble and the high field is 2 bits wide. Software fills the fields over a small register bus, using byte writes or single-bit writes. A trigger pulse then copies the buffered data into an output latch. After that, software can load the next value without disturbing the pins.

A mode bit selects between two layouts:

- **Split mode:** the nibble and the 2-bit field are two separate channels. Each channel has its own bus address and its own trigger input.
- **Joined mode:** the two fields form one 6-bit channel. A byte or bit written to either buffer address updates both fields. The low trigger moves all six bits together, and the high trigger does nothing.

A per-pin enable chooses what each output pin shows: the latched real-time value, or a default port value supplied from outside.

The register bus is a control path, so it has plain strobes and no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. A read is combinational on `bus_addr`.

Top module: `rtout_unit`

## Requirements
- R1: After reset, both buffer fields, the output latch, the pin-enable register and the mode bit are 0. Every address reads 00h, and `pin_out` equals `port_dflt`.
- R2: A read at address 0 or address 1 returns the merged byte {2'b00, high field, low nibble}: the high field in bits 5:4 and the nibble in bits 3:0. Bits 7:6 always read 0, whatever was written to them.
- R3: With the mode bit at 0, a write to address 0 loads only the nibble from bits 3:0. A write to address 1 loads only the high field from bits 5:4. The other field is left unchanged.
- R4: With the mode bit at 1, a byte write to either address 0 or address 1 loads both fields from bits 5:0 of that byte.
- R5: A bit write (`bus_bit`=1) applies to the merged byte. Bit `bus_bidx` takes the value `bus_bval`, and the result is stored under the same rules as R3 and R4. An index of 6 or 7 changes nothing.
- R6: With the mode bit at 0, `trig_lo` copies the nibble into latch bits 3:0 and `trig_hi` copies the high field into latch bits 5:4. Each trigger works independently of the other and can fire in the same cycle.
- R7: With the mode bit at 1, `trig_lo` copies all six buffer bits into the latch at one edge, and `trig_hi` has no effect.
- R8: A trigger samples the buffer as it was before a write in the same cycle. Without a trigger, the latch holds its value.
- R9: `pin_out[i]` equals latch bit i when enable bit i is 1, and `port_dflt[i]` otherwise.
- R10: Address 2 holds the pin enables in bits 5:0. Address 3 holds the mode bit in bit 0. Both accept byte and bit writes, and their unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_bit | input | 1 | 1 = single-bit write, 0 = byte write |
| bus_addr | input | 2 | 0 nibble buffer, 1 high buffer, 2 pin enables, 3 mode |
| bus_wdata | input | 8 | Byte write data |
| bus_bidx | input | 3 | Bit index for a bit write |
| bus_bval | input | 1 | Bit value for a bit write |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| trig_lo | input | 1 | Trigger for the nibble channel (and for the whole channel in joined mode) |
| trig_hi | input | 1 | Trigger for the 2-bit channel |
| port_dflt | input | 6 | Default pin values |
| pin_out | output | 6 | Output pins |

## Verification
The main overlap is a buffer write and a trigger landing on the same clock edge. The trigger must move the old buffer contents, and the new data must appear only at the next trigger. A mode-bit write in the same cycle as a trigger is a second overlap: the trigger must follow the mode that was in force before the edge.

A directed case in joined mode writes and triggers together, then triggers again. The bench checks the pins after each step. Random cycles raise writes, bit writes, mode changes and both triggers at the same time. After every cycle, the bench compares all four read addresses and the pins against a model that applies triggers from the pre-edge state.

// File: rtl/rtout_pkg.sv
package rtout_pkg;
  localparam int unsigned BUS_W = 8;
  localparam int unsigned IDX_W = $clog2(BUS_W);

  typedef enum logic [1:0] {
    A_NIB  = 2'd0,
    A_HIF  = 2'd1,
    A_PEN  = 2'd2,
    A_MODE = 2'd3
  } rt_addr_e;
endpackage

// File: rtl/rtout_buf.sv
module rtout_buf #(
  parameter int unsigned LO_W  = 4,
  parameter int unsigned HI_W  = 2,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned FW   = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_lo,
  input  logic             sel_hi,
  input  logic             bitw,
  input  logic [FW-1:0]    wdata,
  input  logic [IDX_W-1:0] bidx,
  input  logic             bval,
  input  logic             joined,
  output logic [LO_W-1:0]  lo_q,
  output logic [HI_W-1:0]  hi_q
);
  logic [FW-1:0] eff;
  logic          upd_lo, upd_hi;

  always_comb begin
    eff = wdata;
    if (bitw) begin
      eff = {hi_q, lo_q};
      for (int i = 0; i < FW; i++)
        if (bidx == IDX_W'(i)) eff[i] = bval;
    end
  end

  assign upd_lo = sel_lo | (joined & sel_hi);
  assign upd_hi = sel_hi | (joined & sel_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (upd_lo) lo_q <= eff[LO_W-1:0];
      if (upd_hi) hi_q <= eff[FW-1:LO_W];
    end
  end

  p_split_lo_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lo && !joined) |=> $stable(hi_q));
  p_split_hi_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi && !joined) |=> $stable(lo_q));
  p_joined_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bitw && joined && (sel_lo || sel_hi)) |=> ({hi_q, lo_q} == $past(wdata)));
endmodule

// File: rtl/rtout_latch.sv
module rtout_latch #(
  parameter int unsigned LO_W = 4,
  parameter int unsigned HI_W = 2,
  localparam int unsigned FW  = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LO_W-1:0] lo_d,
  input  logic [HI_W-1:0] hi_d,
  input  logic            trig_lo,
  input  logic            trig_hi,
  input  logic            joined,
  output logic [FW-1:0]   q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (trig_lo) begin
        if (joined) q <= {hi_d, lo_d};
        else        q[LO_W-1:0] <= lo_d;
      end
      if (trig_hi && !joined) q[FW-1:LO_W] <= hi_d;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_lo && !trig_hi) |=> $stable(q));
  p_lo_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_lo |=> (q[LO_W-1:0] == $past(lo_d)));
  p_joined_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (joined && trig_lo) |=> (q == {$past(hi_d), $past(lo_d)}));
  p_joined_hi_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (joined && trig_hi && !trig_lo) |=> $stable(q));
endmodule

// File: rtl/rtout_pinmux.sv
module rtout_pinmux #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] rt_val,
  input  logic [W-1:0] pen,
  input  logic [W-1:0] dflt,
  output logic [W-1:0] pins
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    assign pins[g] = pen[g] ? rt_val[g] : dflt[g];
  end
endmodule

// File: rtl/rtout_unit.sv
module rtout_unit
  import rtout_pkg::*;
#(
  parameter int unsigned LO_W = 4,
  parameter int unsigned HI_W = 2,
  localparam int unsigned FW  = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_bit,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic [IDX_W-1:0] bus_bidx,
  input  logic             bus_bval,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             trig_lo,
  input  logic             trig_hi,
  input  logic [FW-1:0]    port_dflt,
  output logic [FW-1:0]    pin_out
);
  rt_addr_e      addr;
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic [FW-1:0]   latch_q, pen_q, pen_eff;
  logic            mode_q, mode_eff;
  logic            wr_unused;

  assign addr      = rt_addr_e'(bus_addr);
  assign wr_unused = ^bus_wdata[BUS_W-1:FW];

  rtout_buf #(.LO_W(LO_W), .HI_W(HI_W), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .sel_lo(bus_wr && addr == A_NIB), .sel_hi(bus_wr && addr == A_HIF),
    .bitw(bus_bit), .wdata(bus_wdata[FW-1:0]), .bidx(bus_bidx), .bval(bus_bval),
    .joined(mode_q), .lo_q(lo_q), .hi_q(hi_q)
  );

  rtout_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .lo_d(lo_q), .hi_d(hi_q),
    .trig_lo(trig_lo), .trig_hi(trig_hi), .joined(mode_q), .q(latch_q)
  );

  rtout_pinmux #(.W(FW)) u_mux (
    .rt_val(latch_q), .pen(pen_q), .dflt(port_dflt), .pins(pin_out)
  );

  always_comb begin
    pen_eff  = bus_wdata[FW-1:0];
    mode_eff = bus_wdata[0];
    if (bus_bit) begin
      pen_eff  = pen_q;
      mode_eff = (bus_bidx == '0) ? bus_bval : mode_q;
      for (int i = 0; i < FW; i++)
        if (bus_bidx == IDX_W'(i)) pen_eff[i] = bus_bval;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q  <= '0;
      mode_q <= 1'b0;
    end else if (bus_wr) begin
      if (addr == A_PEN)  pen_q  <= pen_eff;
      if (addr == A_MODE) mode_q <= mode_eff;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (addr)
      A_NIB, A_HIF: bus_rdata[FW-1:0] = {hi_q, lo_q};
      A_PEN:        bus_rdata[FW-1:0] = pen_q;
      default:      bus_rdata[0]      = mode_q;
    endcase
  end

  p_mode_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_bit && addr == A_MODE) |=> (mode_q == $past(bus_wdata[0])));
  p_no_write_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(pen_q) && $stable(mode_q)));
endmodule

// File: tb/rtout_unit_bench.sv
module rtout_unit_bench;
  localparam int CLK_PERIOD = 20;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_wr = 0, bus_bit = 0, bus_bval = 0, trig_lo = 0, trig_hi = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [2:0] bus_bidx = 0;
  logic [5:0] port_dflt = 0, pin_out;

  int n_chk = 0, n_bad = 0;
  logic [3:0] m_lo = 0;
  logic [1:0] m_hi = 0;
  logic [5:0] m_lat = 0, m_pen = 0;
  logic       m_mode = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtout_unit u_rtout_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_bit(bus_bit), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_bidx(bus_bidx), .bus_bval(bus_bval), .bus_rdata(bus_rdata),
    .trig_lo(trig_lo), .trig_hi(trig_hi), .port_dflt(port_dflt), .pin_out(pin_out)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] put_bit(input logic [7:0] b, input logic [2:0] i, input logic v);
    logic [7:0] r = b;
    r[i] = v;
    return r;
  endfunction

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0, 2'd1: return {2'b00, m_hi, m_lo};
      2'd2:       return {2'b00, m_pen};
      default:    return {7'd0, m_mode};
    endcase
  endfunction

  function automatic logic [5:0] exp_pins();
    return (m_lat & m_pen) | (port_dflt & ~m_pen);
  endfunction

  task automatic model_edge(input logic wr, bw, input logic [1:0] a, input logic [7:0] wd,
                            input logic [2:0] bi, input logic bv, tl, th);
    logic [7:0] eff;
    if (tl) begin
      if (m_mode) m_lat = {m_hi, m_lo};
      else        m_lat[3:0] = m_lo;
    end
    if (th && !m_mode) m_lat[5:4] = m_hi;
    if (wr) begin
      eff = bw ? put_bit(exp_read(a), bi, bv) : wd;
      case (a)
        2'd0: begin m_lo = eff[3:0]; if (m_mode) m_hi = eff[5:4]; end
        2'd1: begin m_hi = eff[5:4]; if (m_mode) m_lo = eff[3:0]; end
        2'd2: m_pen = eff[5:0];
        default: m_mode = eff[0];
      endcase
    end
  endtask

  task automatic check_all();
    chk("R9 pins", {2'b00, pin_out}, {2'b00, exp_pins()});
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a);
      #1;
      chk(a < 2 ? "R2 buffer read" : "R10 control read", bus_rdata, exp_read(2'(a)));
    end
  endtask

  task automatic step(input logic wr, bw, input logic [1:0] a, input logic [7:0] wd,
                      input logic [2:0] bi, input logic bv, tl, th);
    bus_wr = wr; bus_bit = bw; bus_addr = a; bus_wdata = wd;
    bus_bidx = bi; bus_bval = bv; trig_lo = tl; trig_hi = th;
    @(posedge clk);
    model_edge(wr, bw, a, wd, bi, bv, tl, th);
    @(negedge clk);
    bus_wr = 0; bus_bit = 0; trig_lo = 0; trig_hi = 0;
    check_all();
  endtask

  task automatic wbyte(input logic [1:0] a, input logic [7:0] d);
    step(1, 0, a, d, 0, 0, 0, 0);
  endtask

  task automatic peek(input string tag, input logic [1:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    port_dflt = 6'h2B;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) peek("R1 reset read", 2'(a), 8'h00);
    chk("R1 reset pins", {2'b00, pin_out}, 8'h2B);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: split mode aliasing
    wbyte(2'd0, 8'hFF); peek("R3 nibble only", 2'd1, 8'h0F);
    wbyte(2'd1, 8'hFF); peek("R3 high only", 2'd0, 8'h3F);
    wbyte(2'd0, 8'hF0); peek("R3 nibble cleared", 2'd0, 8'h30);
    // R4: joined mode
    wbyte(2'd3, 8'h01);
    wbyte(2'd1, 8'hA5); peek("R4 joined via high addr", 2'd0, 8'h25);
    wbyte(2'd3, 8'h00);
    // R5: bit writes
    step(1, 1, 2'd0, 0, 3'd4, 1, 0, 0); peek("R5 split bit ignored", 2'd0, 8'h25);
    step(1, 1, 2'd1, 0, 3'd4, 1, 0, 0); peek("R5 split bit high", 2'd0, 8'h35);
    step(1, 1, 2'd1, 0, 3'd7, 1, 0, 0); peek("R5 index 7 no effect", 2'd1, 8'h35);
    wbyte(2'd3, 8'h01);
    step(1, 1, 2'd0, 0, 3'd1, 1, 0, 0); peek("R5 joined bit", 2'd1, 8'h37);
    wbyte(2'd3, 8'h00);
    wbyte(2'd2, 8'h3F);
    // R6: separate triggers
    step(0, 0, 0, 0, 0, 0, 1, 0); chk("R6 low trigger", {2'b00, pin_out}, 8'h07);
    step(0, 0, 0, 0, 0, 0, 0, 1); chk("R6 high trigger", {2'b00, pin_out}, 8'h37);
    // R7: joined trigger
    wbyte(2'd3, 8'h01);
    wbyte(2'd0, 8'h0A);
    step(0, 0, 0, 0, 0, 0, 0, 1); chk("R7 high trigger ignored", {2'b00, pin_out}, 8'h37);
    step(0, 0, 0, 0, 0, 0, 1, 0); chk("R7 all six bits", {2'b00, pin_out}, 8'h0A);
    // R8: write and trigger on the same edge
    step(1, 0, 2'd1, 8'h15, 0, 0, 1, 0); chk("R8 old data moved", {2'b00, pin_out}, 8'h0A);
    step(0, 0, 0, 0, 0, 0, 0, 0);        chk("R8 hold", {2'b00, pin_out}, 8'h0A);
    step(0, 0, 0, 0, 0, 0, 1, 0);        chk("R8 new data", {2'b00, pin_out}, 8'h15);
    // R9: partial pin enables
    port_dflt = 6'h2A;
    wbyte(2'd2, 8'h0F); chk("R9 mixed pins", {2'b00, pin_out}, 8'h25);

    for (int k = 0; k < 1500; k++) begin
      logic [31:0] r;
      r = $urandom;
      port_dflt = 6'($urandom);
      step(r[0] | r[1], r[2] & r[3], r[5:4], 8'($urandom), r[8:6], r[9], r[10], r[11]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule